// File: doc/BRIEF.md
# Ethernet MAC Flow Control Unit

This block handles 802.3x-style flow control for a 10/100 Ethernet MAC. On the receive side it watches the free space left in the receive FIFO. It compares that space against a threshold that software selects with a 3-bit code. When the FIFO is nearly full, it asks the transmitter to send a pause frame. Software can force the same condition with a sticky Xoff latch and release it with an Xon write. A fetched receive descriptor can also set the latch with a one-cycle pulse.

On the transmit side the block takes pause and pause-low commands that the receive path has already decoded, each with its 16-bit pause value. It keeps a pause timer that counts down on a pause-quanta tick. While the timer is nonzero it holds the transmitter off. It also reports two status flags, paused and paused-low, which clear on different events. The block does no frame formatting, CRC, datapath work or DMA.

Top module: `fc_unit`

## Requirements
- R1: After reset, the threshold code reads 000. The Xoff, full, paused and paused-low status bits read 0. No pause request is made and transmit-inhibit is low.
- R2: The threshold code selects a free-byte limit: 000 gives 512, 001 gives 1024, and each later code adds 256, so 111 gives 2560. When `rx_free_bytes` is at or below the limit, the full state is entered two clocks later. When it rises above the limit, the full state is left two clocks later.
- R3: A `cfg_wr` strobe loads `cfg_thresh` into the threshold code, and `stat_thresh` shows the new code on the next clock.
- R4: An `xoff_wr` strobe sets the Xoff latch, and `stat_xoff` reads 1 on the next clock. The full state and a pause request follow one clock after that. The latch stays set until an `xon_wr` strobe clears it. If both strobes come in the same cycle, Xon wins.
- R5: A `desc_fc_pulse` sets the Xoff latch exactly as an Xoff write does, and the latch stays set until Xon.
- R6: `tx_pause_req` is a single-cycle pulse that comes in the same cycle `stat_full` rises. `stat_full` stays 1 while the FIFO is at or below the threshold or the Xoff latch is set.
- R7: While the full state lasts, `tx_pause_req` pulses again after every PAUSE_TIME/2 quanta ticks, counted from entry or from the last repeat.
- R8: A received pause or pause-low command loads the pause timer with its value on the next clock. Each quanta tick lowers a nonzero timer by one. `tx_inhibit` is 1 exactly while the timer is nonzero.
- R9: `stat_paused` is set by a pause command with a nonzero value. It clears in the cycle the timer reaches zero, and a pause command with value 0 clears it at once.
- R10: `stat_paused_low` is set by a pause-low command with a nonzero value. It clears when the timer reaches zero or when any pause command is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Threshold code write strobe |
| cfg_thresh | input | 3 | Threshold code to write |
| xoff_wr | input | 1 | Write-1 strobe that sets the Xoff latch |
| xon_wr | input | 1 | Write-1 strobe that clears the Xoff latch |
| desc_fc_pulse | input | 1 | Fetched descriptor asks for flow control |
| rx_free_bytes | input | FREE_W | Free bytes in the receive FIFO |
| rx_pause_valid | input | 1 | Decoded pause command received |
| rx_pause_low_valid | input | 1 | Decoded pause-low command received |
| rx_pause_value | input | PT_W | Pause time carried by the command |
| quanta_tick | input | 1 | One pulse per pause quantum (512 bit times) |
| tx_pause_req | output | 1 | Pulse: send a pause frame |
| tx_inhibit | output | 1 | Hold off transmission |
| stat_thresh | output | 3 | Current threshold code |
| stat_xoff | output | 1 | Xoff latch state |
| stat_full | output | 1 | Full state (pause being advertised) |
| stat_paused | output | 1 | Paused by a pause command |
| stat_paused_low | output | 1 | Paused by a pause-low command |

## Verification
The assertions assume the receive path never gives a pause and a pause-low command in the same cycle, and that every strobe and tick lasts one cycle. The bench drives each command and tick on its own negative edge and lowers it after one clock, so these assumptions hold. The threshold sweep changes the free-byte count only while no Xoff cause is active, so the full state it sees comes from the comparison alone.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int THR_W = 3;
  typedef logic [THR_W-1:0] thr_code_t;

  // Free-byte limit for a threshold code: 512, then 1024 + 256 per step.
  function automatic int unsigned thr_limit(input thr_code_t code);
    if (code == '0) return 32'd512;
    return 32'd768 + 32'd256 * int'(code);
  endfunction
endpackage

// File: rtl/fc_thresh.sv
module fc_thresh
  import fc_pkg::*;
#(
  parameter int FREE_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  thr_code_t         cfg_code,
  input  logic [FREE_W-1:0] free_bytes,
  output thr_code_t         code_q,
  output logic              fifo_low
);
  logic [FREE_W-1:0] limit;

  always_comb limit = FREE_W'(thr_limit(code_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= '0;
      fifo_low <= 1'b0;
    end else begin
      if (cfg_wr) code_q <= cfg_code;
      fifo_low <= (free_bytes <= limit);
    end
  end
endmodule

// File: rtl/fc_xoff.sv
module fc_xoff (
  input  logic clk,
  input  logic rst,
  input  logic xoff_wr,
  input  logic xon_wr,
  input  logic desc_pulse,
  output logic xoff_q
);
  always_ff @(posedge clk) begin
    if (rst)                        xoff_q <= 1'b0;
    else if (xon_wr)                xoff_q <= 1'b0;
    else if (xoff_wr || desc_pulse) xoff_q <= 1'b1;
  end

  // R4
  xon_clears_chk: assert property (@(posedge clk) disable iff (rst)
    xon_wr |=> !xoff_q);
  // R5
  xoff_sets_chk: assert property (@(posedge clk) disable iff (rst)
    ((xoff_wr || desc_pulse) && !xon_wr) |=> xoff_q);
endmodule

// File: rtl/fc_tx_req.sv
module fc_tx_req #(
  parameter int PAUSE_TIME = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic full_cond,
  input  logic tick,
  output logic full_q,
  output logic req
);
  localparam int HALF  = (PAUSE_TIME / 2 < 1) ? 1 : PAUSE_TIME / 2;
  localparam int CNT_W = $clog2(HALF + 1);

  logic [CNT_W-1:0] cnt;
  logic             rpt_due;

  always_comb rpt_due = full_q && full_cond && tick && (cnt == CNT_W'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      req    <= 1'b0;
      cnt    <= '0;
    end else begin
      full_q <= full_cond;
      req    <= full_cond && (!full_q || rpt_due);
      if (!full_cond || !full_q) cnt <= '0;
      else if (tick)             cnt <= rpt_due ? '0 : cnt + 1'b1;
    end
  end

  // R6
  req_single_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);
  // R6
  req_in_full_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> full_q);
  // R6
  entry_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(full_q) |-> req);
endmodule

// File: rtl/fc_rx_pause.sv
module fc_rx_pause #(
  parameter int PT_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pause_v,
  input  logic            pause_low_v,
  input  logic [PT_W-1:0] value,
  input  logic            tick,
  output logic            inhibit,
  output logic            paused,
  output logic            paused_low
);
  logic [PT_W-1:0] timer, timer_n;
  logic            any_cmd;

  always_comb begin
    any_cmd = pause_v || pause_low_v;
    if (any_cmd)                     timer_n = value;
    else if (tick && timer != '0)    timer_n = timer - 1'b1;
    else                             timer_n = timer;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timer      <= '0;
      inhibit    <= 1'b0;
      paused     <= 1'b0;
      paused_low <= 1'b0;
    end else begin
      timer   <= timer_n;
      inhibit <= (timer_n != '0);
      if (pause_v)              paused <= (value != '0);
      else if (timer_n == '0)   paused <= 1'b0;
      if (pause_v)              paused_low <= 1'b0;
      else if (pause_low_v)     paused_low <= (value != '0);
      else if (timer_n == '0)   paused_low <= 1'b0;
    end
  end

  // R8
  inhibit_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(inhibit) |-> $past(tick || pause_v || pause_low_v));
  // R9
  paused_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
    (paused || paused_low) |-> inhibit);
  // R10
  low_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    pause_v |=> !paused_low);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !pause_v && !pause_low_v) |=> $stable(inhibit));
endmodule

// File: rtl/fc_unit.sv
module fc_unit
  import fc_pkg::*;
#(
  parameter int FREE_W     = 13,
  parameter int PT_W       = 16,
  parameter int PAUSE_TIME = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_thresh,
  input  logic              xoff_wr,
  input  logic              xon_wr,
  input  logic              desc_fc_pulse,
  input  logic [FREE_W-1:0] rx_free_bytes,
  input  logic              rx_pause_valid,
  input  logic              rx_pause_low_valid,
  input  logic [PT_W-1:0]   rx_pause_value,
  input  logic              quanta_tick,
  output logic              tx_pause_req,
  output logic              tx_inhibit,
  output logic [2:0]        stat_thresh,
  output logic              stat_xoff,
  output logic              stat_full,
  output logic              stat_paused,
  output logic              stat_paused_low
);
  thr_code_t code_q;
  logic      fifo_low, xoff_q, full_cond;

  fc_thresh #(.FREE_W(FREE_W)) u_thresh (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_code(cfg_thresh),
    .free_bytes(rx_free_bytes), .code_q(code_q), .fifo_low(fifo_low));

  fc_xoff u_xoff (
    .clk(clk), .rst(rst), .xoff_wr(xoff_wr), .xon_wr(xon_wr),
    .desc_pulse(desc_fc_pulse), .xoff_q(xoff_q));

  always_comb full_cond = fifo_low || xoff_q;

  fc_tx_req #(.PAUSE_TIME(PAUSE_TIME)) u_tx_req (
    .clk(clk), .rst(rst), .full_cond(full_cond), .tick(quanta_tick),
    .full_q(stat_full), .req(tx_pause_req));

  fc_rx_pause #(.PT_W(PT_W)) u_rx_pause (
    .clk(clk), .rst(rst), .pause_v(rx_pause_valid),
    .pause_low_v(rx_pause_low_valid), .value(rx_pause_value),
    .tick(quanta_tick), .inhibit(tx_inhibit), .paused(stat_paused),
    .paused_low(stat_paused_low));

  always_comb stat_thresh = code_q;
  always_comb stat_xoff   = xoff_q;

  // R4
  xoff_full_chk: assert property (@(posedge clk) disable iff (rst)
    stat_xoff |=> stat_full);
  // R3
  thresh_load_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (stat_thresh == $past(cfg_thresh)));
endmodule

// File: tb/test_fc_unit.sv
module test_fc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int FREE_W = 13;
  localparam int PT_W = 16;
  localparam int PT = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_wr = 0, xoff_wr = 0, xon_wr = 0, desc_fc_pulse = 0;
  logic [2:0] cfg_thresh = '0;
  logic [FREE_W-1:0] rx_free_bytes = 13'd4000;
  logic rx_pause_valid = 0, rx_pause_low_valid = 0, quanta_tick = 0;
  logic [PT_W-1:0] rx_pause_value = '0;
  logic tx_pause_req, tx_inhibit, stat_xoff, stat_full, stat_paused, stat_paused_low;
  logic [2:0] stat_thresh;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fc_unit #(.FREE_W(FREE_W), .PT_W(PT_W), .PAUSE_TIME(PT)) i_fc_unit (
    .clk, .rst, .cfg_wr, .cfg_thresh, .xoff_wr, .xon_wr, .desc_fc_pulse,
    .rx_free_bytes, .rx_pause_valid, .rx_pause_low_valid, .rx_pause_value,
    .quanta_tick, .tx_pause_req, .tx_inhibit, .stat_thresh, .stat_xoff,
    .stat_full, .stat_paused, .stat_paused_low);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance n clocks, ending just after a negative edge
  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    quanta_tick = 1; cyc(1); quanta_tick = 0;
  endtask

  task automatic pause_cmd(input bit low, input int val);
    rx_pause_value = PT_W'(val);
    if (low) rx_pause_low_valid = 1; else rx_pause_valid = 1;
    cyc(1);
    rx_pause_valid = 0; rx_pause_low_valid = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    cyc(3); rst = 0; cyc(1);
    // R1 reset state
    chk("R1 thresh", stat_thresh, 0);
    chk("R1 xoff", stat_xoff, 0);
    chk("R1 full", stat_full, 0);
    chk("R1 req", tx_pause_req, 0);
    chk("R1 inhibit", tx_inhibit, 0);
    chk("R1 paused", stat_paused, 0);
    chk("R1 paused_low", stat_paused_low, 0);

    // R2/R3/R6 sweep of every threshold code
    for (int c = 0; c < 8; c++) begin
      int lim;
      lim = (c == 0) ? 512 : 768 + 256 * c;
      cfg_thresh = 3'(c); cfg_wr = 1; cyc(1); cfg_wr = 0;
      chk("R3 thresh readback", stat_thresh, c);
      rx_free_bytes = FREE_W'(lim + 1); cyc(3);
      chk("R2 above limit not full", stat_full, 0);
      rx_free_bytes = FREE_W'(lim); cyc(1);
      chk("R2 one clock not yet full", stat_full, 0);
      cyc(1);
      chk("R2 at limit full", stat_full, 1);
      chk("R6 request on entry", tx_pause_req, 1);
      rx_free_bytes = FREE_W'(lim - 100); cyc(1);
      chk("R6 request single pulse", tx_pause_req, 0);
      chk("R6 full held", stat_full, 1);
      rx_free_bytes = FREE_W'(lim + 1); cyc(2);
      chk("R2 leaves full", stat_full, 0);
    end

    // R7 repeat after PT/2 ticks while full
    rx_free_bytes = 13'd100; cyc(2);
    chk("R7 entry request", tx_pause_req, 1);
    for (int i = 1; i <= PT/2; i++) begin
      tick();
      chk("R7 repeat timing", tx_pause_req, (i == PT/2) ? 1 : 0);
    end
    for (int i = 1; i <= PT/2; i++) begin
      tick();
      chk("R7 second repeat", tx_pause_req, (i == PT/2) ? 1 : 0);
    end
    rx_free_bytes = 13'd4000; cyc(3);
    chk("R7 full cleared", stat_full, 0);

    // R4 Xoff / Xon
    xoff_wr = 1; cyc(1); xoff_wr = 0;
    chk("R4 xoff set", stat_xoff, 1);
    chk("R4 full not yet", stat_full, 0);
    cyc(1);
    chk("R4 full via xoff", stat_full, 1);
    chk("R4 request via xoff", tx_pause_req, 1);
    cyc(5);
    chk("R4 xoff sticky", stat_xoff, 1);
    xon_wr = 1; cyc(1); xon_wr = 0;
    chk("R4 xon clears", stat_xoff, 0);
    cyc(1);
    chk("R4 full leaves", stat_full, 0);
    xoff_wr = 1; xon_wr = 1; cyc(1); xoff_wr = 0; xon_wr = 0;
    chk("R4 xon wins", stat_xoff, 0);

    // R5 descriptor pulse
    desc_fc_pulse = 1; cyc(1); desc_fc_pulse = 0;
    chk("R5 desc sets xoff", stat_xoff, 1);
    cyc(1);
    chk("R5 desc request", tx_pause_req, 1);
    cyc(4);
    chk("R5 sticky", stat_xoff, 1);
    xon_wr = 1; cyc(1); xon_wr = 0; cyc(1);
    chk("R5 cleared by xon", stat_xoff, 0);

    // R8/R9 pause timer sweep
    for (int v = 1; v <= 5; v++) begin
      pause_cmd(0, v);
      chk("R8 inhibit on load", tx_inhibit, 1);
      chk("R9 paused set", stat_paused, 1);
      cyc(3);
      chk("R8 no tick holds", tx_inhibit, 1);
      for (int t = 1; t <= v; t++) begin
        tick();
        chk("R8 inhibit countdown", tx_inhibit, (t < v) ? 1 : 0);
        chk("R9 paused countdown", stat_paused, (t < v) ? 1 : 0);
      end
    end
    pause_cmd(0, 40);
    pause_cmd(0, 0);
    chk("R9 zero clears paused", stat_paused, 0);
    chk("R8 zero clears inhibit", tx_inhibit, 0);

    // R10 pause-low
    pause_cmd(1, 2);
    chk("R10 low set", stat_paused_low, 1);
    chk("R10 low not paused", stat_paused, 0);
    tick(); tick();
    chk("R10 low cleared at zero", stat_paused_low, 0);
    pause_cmd(1, 30);
    pause_cmd(0, 20);
    chk("R10 pause clears low", stat_paused_low, 0);
    chk("R10 paused after pause", stat_paused, 1);
    chk("R8 reloaded inhibit", tx_inhibit, 1);
    pause_cmd(0, 0);
    chk("R8 inhibit off", tx_inhibit, 0);

    finish_run();
  end
endmodule